// File: doc/BRIEF.md
# Accumulator Rotate and Nibble-Rotate Unit

This unit carries out the rotate operations of a small 8-bit processor core. Four single-bit rotates act on the accumulator: plain circular rotates left or right, and rotates that pass through the carry flag. Two nibble rotates move 4-bit digits in a cycle among three places: the low nibble of the accumulator and the two nibbles of a memory byte. The high nibble of the accumulator stays as it was.

The sequencer pulses `start` with an operation code, the accumulator, the memory byte and the carry flag. The unit latches these operands and stays `busy` for the operation's full cycle count. A bit rotate takes 2 cycles. A nibble rotate takes 10 cycles when the byte sits in fast on-chip RAM (`mem_fast` = 1) and 12 cycles otherwise. In the last cycle `done` is high and the results are valid. For a nibble rotate, `mem_we` is high in that same single cycle, so the new memory byte is written back once. Address generation and bus sequencing belong to the surrounding core.

Top module: `acc_rotate_unit`

## Requirements
- R1: Operation code 0 (rotate right): the result accumulator is the input shifted down one place with input bit 0 moved to bit 7, and the carry result equals input bit 0.
- R2: Operation code 1 (rotate left): the result accumulator is the input shifted up one place with input bit 7 moved to bit 0, and the carry result equals input bit 7.
- R3: Operation code 2 (rotate right through carry): bit 7 of the result takes the old carry, the other bits shift down one place, and the carry result is the old bit 0.
- R4: Operation code 3 (rotate left through carry): bit 0 of the result takes the old carry, the other bits shift up one place, and the carry result is the old bit 7.
- R5: Operation code 4 (nibble rotate right): the accumulator low nibble becomes the memory low nibble, the memory high nibble becomes the old accumulator low nibble, the memory low nibble becomes the old memory high nibble, and the accumulator high nibble is unchanged.
- R6: Operation code 5 (nibble rotate left): the accumulator low nibble becomes the memory high nibble, the memory low nibble becomes the old accumulator low nibble, the memory high nibble becomes the old memory low nibble, and the accumulator high nibble is unchanged.
- R7: A bit rotate lasts 2 cycles: with acceptance at clock edge k, `done` is high only in the cycle after edge k+1, and `mem_we` stays low throughout.
- R8: A nibble rotate lasts 10 cycles when `mem_fast` is 1 at acceptance and 12 cycles when it is 0: `done` is high only in the cycle after edge k+9 or k+11.
- R9: A nibble rotate returns the input carry unchanged on `carry_out` and raises `mem_we` for exactly one cycle, the cycle in which `done` is high.
- R10: A `start` while `busy` is high, or with operation code 6 or 7, is not accepted: it leaves `busy` low when idle and does not alter the results of the operation in progress.
- R11: While reset is active, `busy`, `done` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle with a valid code |
| op | input | 3 | Operation code (0..5 valid) |
| mem_fast | input | 1 | Memory byte lies in fast on-chip RAM |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory byte operand |
| carry_in | input | 1 | Carry flag operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation; results valid |
| acc_out | output | 8 | New accumulator |
| mem_out | output | 8 | New memory byte |
| mem_we | output | 1 | Write strobe for the memory byte |
| carry_out | output | 1 | New carry flag |

## Verification
Results are due in the last cycle of each operation: one edge after acceptance for a bit rotate, nine edges after for a nibble rotate in fast RAM, and eleven edges after otherwise. The driver records the cycle number at the acceptance edge with each expected item. The monitor samples on falling edges, so when `done` appears it checks both the values and the elapsed cycle count against the latency the requirement gives. A `mem_we` outside a `done` cycle, or a `done` with no pending item, is reported as a failure. This catches early, late and repeated write-backs.

// File: rtl/rot_pkg.sv
package rot_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  typedef enum logic [2:0] {
    OP_ROR  = 3'd0,
    OP_ROL  = 3'd1,
    OP_RORC = 3'd2,
    OP_ROLC = 3'd3,
    OP_NRR  = 3'd4,
    OP_NRL  = 3'd5
  } rot_op_e;

  function automatic logic op_is_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic op_is_nibble(input logic [2:0] code);
    return code[2];
  endfunction

  // Single-bit rotate; fill is the bit that enters the vacated end.
  function automatic logic [BYTE_W-1:0] rot_right(input logic [BYTE_W-1:0] v,
                                                  input logic fill);
    return {fill, v[BYTE_W-1:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] rot_left(input logic [BYTE_W-1:0] v,
                                                 input logic fill);
    return {v[BYTE_W-2:0], fill};
  endfunction

  typedef struct packed {
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] mem;
  } nib_pair_t;

  // Nibble rotation through acc low nibble and both memory nibbles.
  function automatic nib_pair_t nib_rotate(input logic left,
                                           input logic [BYTE_W-1:0] a,
                                           input logic [BYTE_W-1:0] m);
    nib_pair_t r;
    r.acc[BYTE_W-1:NIB_W] = a[BYTE_W-1:NIB_W];
    if (left) begin
      r.acc[NIB_W-1:0]      = m[BYTE_W-1:NIB_W];
      r.mem[BYTE_W-1:NIB_W] = m[NIB_W-1:0];
      r.mem[NIB_W-1:0]      = a[NIB_W-1:0];
    end else begin
      r.acc[NIB_W-1:0]      = m[NIB_W-1:0];
      r.mem[BYTE_W-1:NIB_W] = a[NIB_W-1:0];
      r.mem[NIB_W-1:0]      = m[BYTE_W-1:NIB_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/rot_bit_unit.sv
module rot_bit_unit
  import rot_pkg::*;
(
  input  logic              go_left,
  input  logic              via_carry,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              cin,
  output logic [BYTE_W-1:0] data_out,
  output logic              cout
);

  logic out_bit;
  logic fill_bit;

  // Bit leaving the byte always becomes the new carry.
  assign out_bit  = go_left ? data_in[BYTE_W-1] : data_in[0];
  assign fill_bit = via_carry ? cin : out_bit;

  always_comb begin
    if (go_left) data_out = rot_left(data_in, fill_bit);
    else         data_out = rot_right(data_in, fill_bit);
  end

  assign cout = out_bit;

endmodule

// File: rtl/rot_nibble_unit.sv
module rot_nibble_unit
  import rot_pkg::*;
(
  input  logic              go_left,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] mem_in,
  output logic [BYTE_W-1:0] acc_out,
  output logic [BYTE_W-1:0] mem_out
);

  nib_pair_t res;

  assign res     = nib_rotate(go_left, acc_in, mem_in);
  assign acc_out = res.acc;
  assign mem_out = res.mem;

endmodule

// File: rtl/rot_timer.sv
module rot_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] remain_q;
  logic             busy_q;
  logic             last_cycle;

  assign last_cycle = busy_q && (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (load && !busy_q) begin
      busy_q   <= 1'b1;
      remain_q <= len - 1'b1;
    end else if (busy_q) begin
      if (last_cycle) busy_q <= 1'b0;
      else            remain_q <= remain_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = last_cycle;

  // Independent elapsed-cycle counter used only by the checks below.
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      len_q     <= '0;
    end else if (load && !busy_q) begin
      elapsed_q <= CNT_W'(1);
      len_q     <= len;
    end else if (busy_q) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  p_len_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (elapsed_q == len_q));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit
  import rot_pkg::*;
#(
  parameter int unsigned BIT_CYC      = 2,
  parameter int unsigned NIB_FAST_CYC = 10,
  parameter int unsigned NIB_SLOW_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op,
  input  logic       mem_fast,
  input  logic [7:0] acc_in,
  input  logic [7:0] mem_in,
  input  logic       carry_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] acc_out,
  output logic [7:0] mem_out,
  output logic       mem_we,
  output logic       carry_out
);

  localparam int unsigned MAX_CYC = (NIB_SLOW_CYC > NIB_FAST_CYC) ? NIB_SLOW_CYC : NIB_FAST_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // Operand latch, captured on acceptance.
  logic [2:0]        op_q;
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] mem_q;
  logic              cy_q;

  logic              accept;
  logic [CNT_W-1:0]  len_sel;

  assign accept = start && !busy && op_is_valid(op);

  always_comb begin
    if (!op_is_nibble(op))  len_sel = CNT_W'(BIT_CYC);
    else if (mem_fast)      len_sel = CNT_W'(NIB_FAST_CYC);
    else                    len_sel = CNT_W'(NIB_SLOW_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= 3'd0;
      acc_q <= '0;
      mem_q <= '0;
      cy_q  <= 1'b0;
    end else if (accept) begin
      op_q  <= op;
      acc_q <= acc_in;
      mem_q <= mem_in;
      cy_q  <= carry_in;
    end
  end

  // Datapath units.
  logic [BYTE_W-1:0] bit_acc;
  logic              bit_cy;
  logic [BYTE_W-1:0] nib_acc;
  logic [BYTE_W-1:0] nib_mem;

  rot_bit_unit u_bit (
    .go_left  (op_q[0]),
    .via_carry(op_q[1]),
    .data_in  (acc_q),
    .cin      (cy_q),
    .data_out (bit_acc),
    .cout     (bit_cy)
  );

  rot_nibble_unit u_nib (
    .go_left(op_q[0]),
    .acc_in (acc_q),
    .mem_in (mem_q),
    .acc_out(nib_acc),
    .mem_out(nib_mem)
  );

  rot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .len  (len_sel),
    .busy (busy),
    .done (done)
  );

  logic is_nib;
  assign is_nib = op_is_nibble(op_q);

  assign acc_out   = is_nib ? nib_acc : bit_acc;
  assign mem_out   = nib_mem;
  assign carry_out = is_nib ? cy_q : bit_cy;
  assign mem_we    = done && is_nib;

  // Checks next to the logic they guard.
  p_we_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);

  p_nib_keeps_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_nib) |-> (carry_out == cy_q));

  p_nib_acc_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_nib) |-> (acc_out[BYTE_W-1:NIB_W] == acc_q[BYTE_W-1:NIB_W]));

  p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(acc_q) && $stable(mem_q)));

  p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_is_valid(op)) |=> !busy);

  p_bit_carry_is_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_nib) |-> (carry_out == (op_q[0] ? acc_q[BYTE_W-1] : acc_q[0])));

  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> (!busy && !mem_we));

endmodule

// File: tb/acc_rotate_unit_test.sv
module acc_rotate_unit_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = 3'd0;
  logic       mem_fast = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] mem_in = 8'h00;
  logic       carry_in = 1'b0;
  logic       busy, done, mem_we, carry_out;
  logic [7:0] acc_out, mem_out;

  acc_rotate_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mem_fast(mem_fast),
    .acc_in(acc_in), .mem_in(mem_in), .carry_in(carry_in),
    .busy(busy), .done(done), .acc_out(acc_out), .mem_out(mem_out),
    .mem_we(mem_we), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] mem;
    logic       cy;
    logic       we;
    int         lat;
    int         stamp;
    string      tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected model, written from the requirement text.
  task automatic model(input logic [2:0] code, input logic [7:0] a,
                       input logic [7:0] m, input logic c, input logic fast,
                       output item_t it);
    it.mem = 8'h00; it.we = 1'b0; it.cy = c; it.acc = a; it.lat = 2;
    case (code)
      3'd0: begin it.acc = (a >> 1) | (a << 7); it.cy = a[0]; it.tag = "R1"; end
      3'd1: begin it.acc = (a << 1) | (a >> 7); it.cy = a[7]; it.tag = "R2"; end
      3'd2: begin it.acc = (a >> 1) | {c, 7'b0}; it.cy = a[0]; it.tag = "R3"; end
      3'd3: begin it.acc = (a << 1) | {7'b0, c}; it.cy = a[7]; it.tag = "R4"; end
      3'd4: begin
        it.acc = (a & 8'hF0) | (m & 8'h0F);
        it.mem = ((a & 8'h0F) << 4) | (m >> 4);
        it.we = 1'b1; it.lat = fast ? 10 : 12; it.tag = "R5";
      end
      default: begin
        it.acc = (a & 8'hF0) | (m >> 4);
        it.mem = ((m & 8'h0F) << 4) | (a & 8'h0F);
        it.we = 1'b1; it.lat = fast ? 10 : 12; it.tag = "R6";
      end
    endcase
  endtask

  task automatic drive(input logic [2:0] code, input logic [7:0] a,
                       input logic [7:0] m, input logic c, input logic fast);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    model(code, a, m, c, fast, it);
    start = 1'b1; op = code; acc_in = a; mem_in = m; carry_in = c; mem_fast = fast;
    @(posedge clk);
    #1;
    it.stamp = cyc;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: compare at falling edges when results are due.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && !done)
        check(1'b0, "R9", "mem_we outside done", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "done with nothing pending", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(acc_out == it.acc, it.tag, "acc_out", acc_out, it.acc);
          check(carry_out == it.cy, it.tag, "carry_out", carry_out, it.cy);
          if (it.we) begin
            check(mem_out == it.mem, it.tag, "mem_out", mem_out, it.mem);
            check(mem_we == 1'b1, "R9", "mem_we", mem_we, 1);
            check(cyc - it.stamp + 1 == it.lat, "R8", "latency",
                  cyc - it.stamp + 1, it.lat);
          end else begin
            check(mem_we == 1'b0, "R7", "mem_we", mem_we, 0);
            check(cyc - it.stamp + 1 == it.lat, "R7", "latency",
                  cyc - it.stamp + 1, it.lat);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && mem_we == 0, "R11", "reset outputs",
          {busy, done, mem_we}, 0);
    rst_n = 1'b1;

    // R1..R4 with several bit patterns and both carry values
    drive(3'd0, 8'h81, 8'h00, 1'b0, 1'b1);
    drive(3'd0, 8'h5A, 8'h00, 1'b1, 1'b0);
    drive(3'd1, 8'h81, 8'h00, 1'b0, 1'b1);
    drive(3'd1, 8'h3C, 8'h00, 1'b1, 1'b1);
    drive(3'd2, 8'h01, 8'h00, 1'b0, 1'b1);
    drive(3'd2, 8'h80, 8'h00, 1'b1, 1'b1);
    drive(3'd3, 8'h80, 8'h00, 1'b0, 1'b0);
    drive(3'd3, 8'h01, 8'h00, 1'b1, 1'b1);
    // R5, R6 and R8 in fast and slow memory
    drive(3'd4, 8'hA7, 8'h3C, 1'b1, 1'b1);
    drive(3'd4, 8'h5E, 8'hF1, 1'b0, 1'b0);
    drive(3'd5, 8'hA7, 8'h3C, 1'b0, 1'b1);
    drive(3'd5, 8'h12, 8'h9B, 1'b1, 1'b0);

    // R10: start while busy must not disturb the running operation
    drive(3'd4, 8'hC3, 8'h6D, 1'b1, 1'b0);
    start = 1'b1; op = 3'd1; acc_in = 8'hFF; mem_in = 8'h00; carry_in = 1'b0; mem_fast = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);

    // R10: reserved code is not accepted
    @(negedge clk);
    start = 1'b1; op = 3'd6;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R10", "busy after reserved op 6", busy, 0);
    start = 1'b1; op = 3'd7;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R10", "busy after reserved op 7", busy, 0);
    repeat (3) @(negedge clk);

    // back-to-back after ignored requests
    drive(3'd2, 8'hFE, 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R7", "pending items at end", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule